// File: doc/BRIEF.md
# System I/O Control Register Block

This block sits on a byte-wide I/O port bus of a workstation board and answers a fixed set of twelve-bit port addresses. It keeps two live byte registers, a system control byte and an I/O map type byte. It returns two bytes fixed at build time, an equipment byte and a board identity byte, through parameters. A handful of write-only ports take data and do nothing with it. Writes to two of the ports drive sideband lines: a soft-reset request and a select for the non-contiguous I/O map. A request for little-endian operation cannot be honoured, so it raises a sticky error line instead.

A second, 32-bit memory-mapped request channel serves one four-byte register that always reads as zero. That register accepts only aligned 32-bit reads. Any other access on that channel still completes, but it pulses a bus-error line for one cycle.

Both channels use valid/ready handshakes. A request is taken on a clock edge where `*_req_valid` and `*_req_ready` are both high. Exactly one response follows from a one-deep response register, and it becomes valid in the next cycle. While a response waits with `*_rsp_ready` low, that channel's `*_req_ready` is low and the response data does not change. A response leaves on the edge where `*_rsp_ready` is high, and a new request can be taken on that same edge.

Bits inside a byte are numbered from the most significant end: bit n has mask `1 << (7-n)`.

Top module: `sysio_ctrl`

## Requirements
- R1: Each accepted request on either channel produces exactly one response, valid in the cycle after acceptance. `*_req_ready` is high whenever no response is pending or `*_rsp_ready` is high. A stalled response keeps its data stable.
- R2: Bit n within a byte has mask `1 << (7-n)`, so bit 7 is mask 0x01 and bit 6 is mask 0x02.
- R3: A write to port 0x092 sets `soft_reset` to bit 7 (mask 0x01) of the data, and the line holds that level until the next write to 0x092. A read of 0x092 returns 0x00.
- R4: A write to port 0x092 with bit 6 (mask 0x02) set raises `le_mode_err`. The line stays high until reset.
- R5: Port 0x81C is a read/write system control byte that resets to 0x00.
- R6: Port 0x850 is a read/write map type byte that resets to 0x00. Each write to it sets `io_map_noncontig` to bit 7 (mask 0x01) of the data.
- R7: Port 0x80C reads as parameter `EQUIP_STRAP` and port 0x852 reads as parameter `BOARD_ID_STRAP`. Writes to either port are ignored.
- R8: Port 0x818 reads as 0x00.
- R9: Ports 0x808, 0x810, 0x812 and 0x814 accept writes with no effect and read as 0xFF. Unmapped ports read as 0xFF, and writes to them are ignored.
- R10: The response to any I/O write carries data 0x00.
- R11: An aligned 32-bit read (size code 2'b10) at memory address `PARITY_BASE` returns 0x00000000 and does not pulse `bus_err`.
- R12: Any other access on the memory channel returns 0x00000000 and pulses `bus_err` high for exactly the cycle after acceptance. This covers a size code other than 2'b10, a write, or any other address.
- R13: After reset, `soft_reset`, `io_map_noncontig`, `le_mode_err`, `bus_err`, `io_rsp_valid` and `mem_rsp_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req_valid | input | 1 | I/O request present |
| io_req_ready | output | 1 | I/O request can be taken |
| io_req_write | input | 1 | 1 = write, 0 = read |
| io_req_addr | input | 12 | I/O port address |
| io_req_wdata | input | 8 | Write data |
| io_rsp_valid | output | 1 | I/O response present |
| io_rsp_ready | input | 1 | I/O response consumer ready |
| io_rsp_rdata | output | 8 | Read data (0x00 for writes) |
| mem_req_valid | input | 1 | Memory request present |
| mem_req_ready | output | 1 | Memory request can be taken |
| mem_req_write | input | 1 | 1 = write, 0 = read |
| mem_req_addr | input | 32 | Byte address |
| mem_req_size | input | 2 | 0 = byte, 1 = half, 2 = word, 3 = reserved |
| mem_rsp_valid | output | 1 | Memory response present |
| mem_rsp_ready | input | 1 | Memory response consumer ready |
| mem_rsp_rdata | output | 32 | Memory read data |
| soft_reset | output | 1 | Soft-reset request level |
| io_map_noncontig | output | 1 | Non-contiguous I/O map select |
| le_mode_err | output | 1 | Sticky unsupported-mode error |
| bus_err | output | 1 | One-cycle memory access error pulse |

## Verification
Two events can land in the same clock edge: a write to port 0x092 on the I/O channel and a bad-sized access on the memory channel. The bench offers both requests in the same cycle, so both are accepted on one edge. In the following cycle it expects `soft_reset` and `bus_err` to be high together, and it expects `bus_err` to fall one cycle later while `soft_reset` holds. A response stall on the I/O channel is also held for several cycles, to show that the request side stays closed and the data does not move.

// File: rtl/sysio_pkg.sv
package sysio_pkg;
  localparam int BYTE_W   = 8;
  localparam int IO_AW    = 12;
  localparam int NPORTS   = 10;
  localparam int SEL_W    = $clog2(NPORTS + 1);

  // port table; index order is the decode priority (all distinct)
  localparam logic [IO_AW-1:0] PORT_ADDR [NPORTS] = '{
    12'h092, 12'h808, 12'h80C, 12'h810, 12'h812,
    12'h814, 12'h818, 12'h81C, 12'h850, 12'h852
  };

  localparam logic [SEL_W-1:0] IX_SPECIAL = 4'd0;
  localparam logic [SEL_W-1:0] IX_DISKLED = 4'd1;
  localparam logic [SEL_W-1:0] IX_EQUIP   = 4'd2;
  localparam logic [SEL_W-1:0] IX_PASS_A  = 4'd3;
  localparam logic [SEL_W-1:0] IX_PASS_B  = 4'd4;
  localparam logic [SEL_W-1:0] IX_L2INV   = 4'd5;
  localparam logic [SEL_W-1:0] IX_KEYLOCK = 4'd6;
  localparam logic [SEL_W-1:0] IX_SYSCTL  = 4'd7;
  localparam logic [SEL_W-1:0] IX_MAPTYPE = 4'd8;
  localparam logic [SEL_W-1:0] IX_BOARDID = 4'd9;
  localparam logic [SEL_W-1:0] IX_NONE    = SEL_W'(NPORTS);

  // MSB-first named bits
  localparam int SRST_BIT = 7;
  localparam int LE_BIT   = 6;
  localparam int NCMAP_BIT = 7;

  localparam logic [1:0] SIZE_WORD = 2'b10;

  function automatic logic [BYTE_W-1:0] bit_mask(input int n);
    return BYTE_W'(1) << (BYTE_W - 1 - n);
  endfunction
endpackage

// File: rtl/sysio_port_decode.sv
module sysio_port_decode
  import sysio_pkg::*;
(
  input  logic [IO_AW-1:0] addr,
  output logic [SEL_W-1:0] sel
);
  logic [NPORTS-1:0] hit;

  for (genvar i = 0; i < NPORTS; i++) begin : g_cmp
    assign hit[i] = (addr == PORT_ADDR[i]);
  end

  always_comb begin
    sel = IX_NONE;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (hit[i]) sel = SEL_W'(i);
    end
  end
endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
  import sysio_pkg::*;
#(
  parameter logic [7:0] EQUIP_STRAP    = 8'h00,
  parameter logic [7:0] BOARD_ID_STRAP = 8'h00
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              soft_reset,
  output logic              noncontig,
  output logic              le_err
);
  logic [BYTE_W-1:0] sysctl_q;
  logic [BYTE_W-1:0] maptype_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sysctl_q   <= '0;
      maptype_q  <= '0;
      soft_reset <= 1'b0;
      noncontig  <= 1'b0;
      le_err     <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        IX_SPECIAL: begin
          soft_reset <= |(wdata & bit_mask(SRST_BIT));
          if (|(wdata & bit_mask(LE_BIT))) le_err <= 1'b1;
        end
        IX_SYSCTL: sysctl_q <= wdata;
        IX_MAPTYPE: begin
          maptype_q <= wdata;
          noncontig <= |(wdata & bit_mask(NCMAP_BIT));
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      IX_SPECIAL, IX_KEYLOCK: rdata = '0;
      IX_EQUIP:               rdata = EQUIP_STRAP;
      IX_BOARDID:             rdata = BOARD_ID_STRAP;
      IX_SYSCTL:              rdata = sysctl_q;
      IX_MAPTYPE:             rdata = maptype_q;
      default:                rdata = '1;
    endcase
  end
endmodule

// File: rtl/sysio_parity_win.sv
module sysio_parity_win #(
  parameter int          AW   = 32,
  parameter logic [31:0] BASE = 32'hBFFF_EFF0
)(
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          write,
  output logic          ok
);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);

  assign ok = (addr == BASE_A) && (size == sysio_pkg::SIZE_WORD) && !write;
endmodule

// File: rtl/sysio_rsp_slot.sv
module sysio_rsp_slot #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         rsp_ready,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_data,
  output logic         can_accept
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= ld_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign can_accept = !rsp_valid || rsp_ready;
endmodule

// File: rtl/sysio_ctrl.sv
module sysio_ctrl
  import sysio_pkg::*;
#(
  parameter logic [7:0]  EQUIP_STRAP    = 8'h00,
  parameter logic [7:0]  BOARD_ID_STRAP = 8'h00,
  parameter int          MEM_AW         = 32,
  parameter int          MEM_DW         = 32,
  parameter logic [31:0] PARITY_BASE    = 32'hBFFF_EFF0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req_valid,
  output logic              io_req_ready,
  input  logic              io_req_write,
  input  logic [IO_AW-1:0]  io_req_addr,
  input  logic [BYTE_W-1:0] io_req_wdata,
  output logic              io_rsp_valid,
  input  logic              io_rsp_ready,
  output logic [BYTE_W-1:0] io_rsp_rdata,
  input  logic              mem_req_valid,
  output logic              mem_req_ready,
  input  logic              mem_req_write,
  input  logic [MEM_AW-1:0] mem_req_addr,
  input  logic [1:0]        mem_req_size,
  output logic              mem_rsp_valid,
  input  logic              mem_rsp_ready,
  output logic [MEM_DW-1:0] mem_rsp_rdata,
  output logic              soft_reset,
  output logic              io_map_noncontig,
  output logic              le_mode_err,
  output logic              bus_err
);
  logic              io_acc, mem_acc, win_ok;
  logic [SEL_W-1:0]  sel;
  logic [BYTE_W-1:0] reg_rdata, io_ld;

  assign io_acc  = io_req_valid && io_req_ready;
  assign mem_acc = mem_req_valid && mem_req_ready;

  sysio_port_decode u_dec (.addr(io_req_addr), .sel(sel));

  sysio_regs #(.EQUIP_STRAP(EQUIP_STRAP), .BOARD_ID_STRAP(BOARD_ID_STRAP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(io_acc && io_req_write), .sel(sel),
    .wdata(io_req_wdata), .rdata(reg_rdata), .soft_reset(soft_reset),
    .noncontig(io_map_noncontig), .le_err(le_mode_err)
  );

  assign io_ld = io_req_write ? '0 : reg_rdata;

  sysio_rsp_slot #(.W(BYTE_W)) u_io_slot (
    .clk(clk), .rst_n(rst_n), .load(io_acc), .ld_data(io_ld),
    .rsp_ready(io_rsp_ready), .rsp_valid(io_rsp_valid),
    .rsp_data(io_rsp_rdata), .can_accept(io_req_ready)
  );

  sysio_parity_win #(.AW(MEM_AW), .BASE(PARITY_BASE)) u_win (
    .addr(mem_req_addr), .size(mem_req_size), .write(mem_req_write), .ok(win_ok)
  );

  sysio_rsp_slot #(.W(MEM_DW)) u_mem_slot (
    .clk(clk), .rst_n(rst_n), .load(mem_acc), .ld_data('0),
    .rsp_ready(mem_rsp_ready), .rsp_valid(mem_rsp_valid),
    .rsp_data(mem_rsp_rdata), .can_accept(mem_req_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bus_err <= 1'b0;
    else        bus_err <= mem_acc && !win_ok;
  end
endmodule

// File: rtl/sysio_ctrl_chk.sv
module sysio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_req_valid,
  input logic        io_req_ready,
  input logic        io_req_write,
  input logic [11:0] io_req_addr,
  input logic [7:0]  io_req_wdata,
  input logic        io_rsp_valid,
  input logic        io_rsp_ready,
  input logic [7:0]  io_rsp_rdata,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic [1:0]  mem_req_size,
  input logic        mem_rsp_valid,
  input logic        mem_rsp_ready,
  input logic [31:0] mem_rsp_rdata,
  input logic        soft_reset,
  input logic        io_map_noncontig,
  input logic        le_mode_err,
  input logic        bus_err
);
  logic io_acc, mem_acc, wr92, wr850;
  assign io_acc  = io_req_valid && io_req_ready;
  assign mem_acc = mem_req_valid && mem_req_ready;
  assign wr92    = io_acc && io_req_write && io_req_addr == 12'h092;
  assign wr850   = io_acc && io_req_write && io_req_addr == 12'h850;

  // R1
  io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rsp_valid && !io_rsp_ready |=> io_rsp_valid && $stable(io_rsp_rdata));
  // R1
  io_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_acc |=> io_rsp_valid);
  // R1
  mem_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rsp_valid |-> mem_req_ready);
  // R3
  srst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr92 |=> soft_reset == $past(io_req_wdata[0]));
  // R3
  srst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr92 |=> $stable(soft_reset));
  // R4
  le_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_mode_err |=> le_mode_err);
  // R6
  ncmap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr850 |=> io_map_noncontig == $past(io_req_wdata[0]));
  // R10
  wr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_acc && io_req_write |=> io_rsp_rdata == 8'h00);
  // R11
  win_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_acc && !mem_req_write && mem_req_size == 2'b10 && mem_req_addr == 32'hBFFF_EFF0
    |=> !bus_err);
  // R12
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err && !mem_acc |=> !bus_err);
  // R12
  mem_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> mem_rsp_rdata == 32'h0);
endmodule

bind sysio_ctrl sysio_ctrl_chk u_chk (.*);

// File: tb/sim_sysio_ctrl.sv
`timescale 1ns/1ps
module sim_sysio_ctrl;
  localparam logic [7:0] EQ = 8'h5A;
  localparam logic [7:0] BD = 8'hC3;

  logic clk = 0, rst_n = 0;
  logic io_req_valid = 0, io_req_write = 0, io_rsp_ready = 1;
  logic [11:0] io_req_addr = 0;
  logic [7:0]  io_req_wdata = 0;
  logic io_req_ready, io_rsp_valid;
  logic [7:0] io_rsp_rdata;
  logic mem_req_valid = 0, mem_req_write = 0, mem_rsp_ready = 1;
  logic [31:0] mem_req_addr = 0;
  logic [1:0]  mem_req_size = 0;
  logic mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic soft_reset, io_map_noncontig, le_mode_err, bus_err;

  always #2.5 clk = ~clk;

  sysio_ctrl #(.EQUIP_STRAP(EQ), .BOARD_ID_STRAP(BD)) u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string rq(input int n);
    case (n)
      2: return "R2"; 3: return "R3"; 4: return "R4"; 5: return "R5";
      6: return "R6"; 7: return "R7"; 8: return "R8"; 9: return "R9";
      10: return "R10"; default: return "R1";
    endcase
  endfunction

  // [35:32] req, [31] wr, [30:19] addr, [18:11] wdata, [10:3] exp data, [2] srst, [1] ncmap, [0] le
  function automatic logic [35:0] mk(input int r, input logic w, input logic [11:0] a,
      input logic [7:0] d, input logic [7:0] e, input logic s, input logic n, input logic l);
    return {4'(r), w, a, d, e, s, n, l};
  endfunction

  localparam int NV = 26;
  localparam logic [35:0] VEC [NV] = '{
    mk(3, 0, 12'h092, 8'h00, 8'h00, 0, 0, 0),
    mk(3, 1, 12'h092, 8'h01, 8'h00, 1, 0, 0),
    mk(3, 0, 12'h092, 8'h00, 8'h00, 1, 0, 0),
    mk(2, 1, 12'h092, 8'h80, 8'h00, 0, 0, 0),
    mk(5, 1, 12'h81C, 8'h3C, 8'h00, 0, 0, 0),
    mk(5, 0, 12'h81C, 8'h00, 8'h3C, 0, 0, 0),
    mk(6, 1, 12'h850, 8'h81, 8'h00, 0, 1, 0),
    mk(6, 0, 12'h850, 8'h00, 8'h81, 0, 1, 0),
    mk(2, 1, 12'h850, 8'h80, 8'h00, 0, 0, 0),
    mk(6, 0, 12'h850, 8'h00, 8'h80, 0, 0, 0),
    mk(7, 0, 12'h80C, 8'h00, EQ,    0, 0, 0),
    mk(10,1, 12'h80C, 8'hFF, 8'h00, 0, 0, 0),
    mk(7, 0, 12'h80C, 8'h00, EQ,    0, 0, 0),
    mk(7, 1, 12'h852, 8'h11, 8'h00, 0, 0, 0),
    mk(7, 0, 12'h852, 8'h00, BD,    0, 0, 0),
    mk(8, 0, 12'h818, 8'h00, 8'h00, 0, 0, 0),
    mk(9, 1, 12'h808, 8'hFF, 8'h00, 0, 0, 0),
    mk(9, 1, 12'h810, 8'hFF, 8'h00, 0, 0, 0),
    mk(9, 1, 12'h812, 8'hFF, 8'h00, 0, 0, 0),
    mk(9, 1, 12'h814, 8'hFF, 8'h00, 0, 0, 0),
    mk(9, 0, 12'h81C, 8'h00, 8'h3C, 0, 0, 0),
    mk(9, 0, 12'h808, 8'h00, 8'hFF, 0, 0, 0),
    mk(9, 0, 12'h123, 8'h00, 8'hFF, 0, 0, 0),
    mk(9, 1, 12'h123, 8'h55, 8'h00, 0, 0, 0),
    mk(4, 1, 12'h092, 8'h03, 8'h00, 1, 0, 1),
    mk(4, 1, 12'h092, 8'h00, 8'h00, 0, 0, 1)
  };

  task automatic io_op(input logic w, input logic [11:0] a, input logic [7:0] d,
                       output logic [7:0] r, output logic v);
    @(negedge clk);
    io_req_valid = 1; io_req_write = w; io_req_addr = a; io_req_wdata = d;
    @(negedge clk);
    io_req_valid = 0;
    r = io_rsp_rdata; v = io_rsp_valid;
  endtask

  task automatic mem_op(input logic w, input logic [31:0] a, input logic [1:0] s);
    @(negedge clk);
    mem_req_valid = 1; mem_req_write = w; mem_req_addr = a; mem_req_size = s;
    @(negedge clk);
    mem_req_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    logic v;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 sideband during reset", {soft_reset, io_map_noncontig, le_mode_err, bus_err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R13 rsp idle", {io_rsp_valid, mem_rsp_valid}, 0);
    chk("R1 ready idle", {io_req_ready, mem_req_ready}, 2'b11);

    for (int i = 0; i < NV; i++) begin
      io_op(VEC[i][31], VEC[i][30:19], VEC[i][18:11], r, v);
      chk({rq(int'(VEC[i][35:32])), " rsp valid"}, v, 1);
      chk({rq(int'(VEC[i][35:32])), " data/sideband"},
          {r, soft_reset, io_map_noncontig, le_mode_err}, {VEC[i][10:3], VEC[i][2:0]});
    end

    // R1 back-pressure: response held, request side closed
    @(negedge clk);
    io_rsp_ready = 0;
    io_req_valid = 1; io_req_write = 0; io_req_addr = 12'h81C;
    @(negedge clk);
    io_req_valid = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R1 stalled rsp", {io_rsp_valid, io_req_ready, io_rsp_rdata}, {2'b10, 8'h3C});
      @(negedge clk);
    end
    io_rsp_ready = 1;
    @(negedge clk);
    chk("R1 rsp drained", {io_rsp_valid, io_req_ready}, 2'b01);

    // R11 good parity read
    mem_op(0, 32'hBFFF_EFF0, 2'b10);
    chk("R11 parity read", {mem_rsp_valid, bus_err, mem_rsp_rdata}, {2'b10, 32'h0});
    // R12 byte access to window
    mem_op(0, 32'hBFFF_EFF0, 2'b00);
    chk("R12 size err", {mem_rsp_valid, bus_err, mem_rsp_rdata}, {2'b11, 32'h0});
    @(negedge clk);
    chk("R12 pulse ends", bus_err, 0);
    // R12 write and out-of-window
    mem_op(1, 32'hBFFF_EFF0, 2'b10);
    chk("R12 write err", bus_err, 1);
    mem_op(0, 32'hBFFF_EFF4, 2'b10);
    chk("R12 addr err", bus_err, 1);

    // same-cycle: soft-reset write and bad memory access
    @(negedge clk);
    io_req_valid = 1; io_req_write = 1; io_req_addr = 12'h092; io_req_wdata = 8'h01;
    mem_req_valid = 1; mem_req_write = 0; mem_req_addr = 32'hBFFF_EFF0; mem_req_size = 2'b01;
    @(negedge clk);
    io_req_valid = 0; mem_req_valid = 0;
    chk("R3/R12 same cycle", {soft_reset, bus_err}, 2'b11);
    @(negedge clk);
    chk("R3/R12 next cycle", {soft_reset, bus_err}, 2'b10);

    // R13 reset clears state; R5 R6 reset values
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R13 after reset", {soft_reset, io_map_noncontig, le_mode_err, bus_err}, 0);
    io_op(0, 12'h81C, 8'h00, r, v);
    chk("R5 sysctl reset", r, 8'h00);
    io_op(0, 12'h850, 8'h00, r, v);
    chk("R6 maptype reset", r, 8'h00);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule